// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block turns the pins of three 8-bit input ports into interrupt requests. Every pin can be set to trigger on a level or on an edge, high/rising or low/falling. It can be enabled on its own, and its input can pass through a debounce filter before detection. Edge events are held in a pending latch until software clears them with a write-one-to-clear acknowledge. Level events follow the pin and are never latched.

Software reaches the configuration and status bytes over a simple byte-wide bus. Writes are single-cycle strobes, and reads are combinational on the address. Ports 0 and 1 merge their status bits into one shared request line. Port 2 gives every pin its own request line.

All pin inputs cross into the clock domain through a two-flop synchroniser. The reset is asynchronous and active-low, and its release is synchronised inside the block, so the internal logic leaves reset two clock edges after the reset input rises.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every configuration byte and status byte reads 0, and `irq_shared_o` and `irq_pin_o` are 0.
- R2: The configuration bytes sit at these offsets for port 0 / port 1 / port 2, and a write to each one reads back unchanged:
  - trigger (bit 1 = edge, 0 = level): 0x90/0xAC/0x4C
  - polarity (bit 1 = high or rising, 0 = low or falling): 0x94/0xB0/0x50
  - enable: 0x9C/0xB8/0x58
  - debounce: 0xA8/0xC4/0x64
- R3: Writes to unmapped offsets and to status offsets change nothing. Reads of unmapped offsets and of the acknowledge offsets return 0.
- R4: In edge mode, the matching pin transition sets the pending bit. The bit becomes visible on the third rising clock edge after the pin changes. A transition of the opposite direction does not set it.
- R5: Writing a byte to the acknowledge offset (0x98/0xB4/0x54) clears the pending bit of each pin written as 1 and leaves the other pins alone. An edge detected in the same cycle as the acknowledge stays pending.
- R6: In level mode, a status bit is 1 while the synchronised pin equals its polarity bit, two clocks after a pin change. An acknowledge has no effect on it.
- R7: A pin whose enable bit is 0 shows status 0 and latches no edge. A pin that is disabled and then enabled again after edges or a configuration change shows no pending bit.
- R8: With its debounce bit set, a pin accepts a new level only after the synchronised input has differed from the accepted level for DB_CYCLES (default 4) consecutive clocks. Shorter pulses are lost.
- R9: Status bytes read at 0xA0/0xBC/0x5C for port 0 / 1 / 2.
- R10: `irq_shared_o` is 1 exactly when any status bit of port 0 or port 1 is 1.
- R11: `irq_pin_o[i]` equals status bit i of port 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wen_i | input | 1 | Write strobe, one cycle per byte |
| bus_addr_i | input | 8 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| pin_p0_i | input | 8 | Port 0 pin inputs |
| pin_p1_i | input | 8 | Port 1 pin inputs |
| pin_p2_i | input | 8 | Port 2 pin inputs |
| irq_shared_o | output | 1 | Combined request of ports 0 and 1 |
| irq_pin_o | output | 8 | Per-pin requests of port 2 |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands on the same clock edge on which a new edge is detected. The stimulus changes the pin at a falling edge. It then times the acknowledge strobe to be high on exactly the third rising edge after that change, which is the edge on which the pending bit is set.

Debounce rejection needs pulses both shorter and longer than the filter window. The bench drives such pulses on a filtered pin and an unfiltered pin at once. A randomised phase then mixes pin toggles with configuration writes, while a behavioural model is compared on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPORT = 3;
  localparam int PW    = 8;
  localparam int AW    = 8;

  // index 0 = port 0, 1 = port 1, 2 = port 2
  localparam logic [NPORT-1:0][AW-1:0] ADR_TRIG = {8'h4C, 8'hAC, 8'h90};
  localparam logic [NPORT-1:0][AW-1:0] ADR_POL  = {8'h50, 8'hB0, 8'h94};
  localparam logic [NPORT-1:0][AW-1:0] ADR_ACK  = {8'h54, 8'hB4, 8'h98};
  localparam logic [NPORT-1:0][AW-1:0] ADR_ENA  = {8'h58, 8'hB8, 8'h9C};
  localparam logic [NPORT-1:0][AW-1:0] ADR_DBN  = {8'h64, 8'hC4, 8'hA8};
  localparam logic [NPORT-1:0][AW-1:0] ADR_STAT = {8'h5C, 8'hBC, 8'hA0};

  typedef struct packed {
    logic [PW-1:0] trig_edge;  // 1 = edge, 0 = level
    logic [PW-1:0] pol_hi;     // 1 = high/rising, 0 = low/falling
    logic [PW-1:0] enable;
    logic [PW-1:0] dbnc;
  } port_cfg_t;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wen_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [PW-1:0]               wdata_i,
  input  logic [NPORT-1:0][PW-1:0]    stat_i,
  output port_cfg_t [NPORT-1:0]       cfg_o,
  output logic [NPORT-1:0][PW-1:0]    ack_o,
  output logic [PW-1:0]               rdata_o
);
  port_cfg_t [NPORT-1:0] cfg_q, cfg_d;
  logic                  cfg_we;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_we = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      ack_o[p] = '0;
      if (wen_i) begin
        if (addr_i == ADR_TRIG[p]) begin cfg_d[p].trig_edge = wdata_i; cfg_we = 1'b1; end
        if (addr_i == ADR_POL[p])  begin cfg_d[p].pol_hi    = wdata_i; cfg_we = 1'b1; end
        if (addr_i == ADR_ENA[p])  begin cfg_d[p].enable    = wdata_i; cfg_we = 1'b1; end
        if (addr_i == ADR_DBN[p])  begin cfg_d[p].dbnc      = wdata_i; cfg_we = 1'b1; end
        if (addr_i == ADR_ACK[p])  ack_o[p] = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (addr_i == ADR_TRIG[p]) rdata_o = cfg_q[p].trig_edge;
      if (addr_i == ADR_POL[p])  rdata_o = cfg_q[p].pol_hi;
      if (addr_i == ADR_ENA[p])  rdata_o = cfg_q[p].enable;
      if (addr_i == ADR_DBN[p])  rdata_o = cfg_q[p].dbnc;
      if (addr_i == ADR_STAT[p]) rdata_o = stat_i[p];
    end
  end

  assign cfg_o = cfg_q;

  AST_ENA_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i && addr_i == ADR_ENA[0]) |=> (cfg_q[0].enable == $past(wdata_i))); // R2
endmodule

// File: rtl/gpio_irq_pin_path.sv
module gpio_irq_pin_path #(
  parameter int PW        = 8,
  parameter int DB_CYCLES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pin_i,
  input  logic [PW-1:0] dbnc_i,
  output logic [PW-1:0] val_o
);
  localparam int            CW   = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

  logic [PW-1:0]         sync1_q, sync2_q, filt_q, filt_d;
  logic [PW-1:0][CW-1:0] cnt_q, cnt_d;

  for (genvar i = 0; i < PW; i++) begin : g_pin
    logic same, done;
    assign same      = (sync2_q[i] == filt_q[i]);
    assign done      = (cnt_q[i] == LAST);
    assign cnt_d[i]  = (same || done) ? '0 : cnt_q[i] + CW'(1);
    assign filt_d[i] = (!same && done) ? sync2_q[i] : filt_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      filt_q  <= '0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      filt_q  <= filt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign val_o = (dbnc_i & filt_q) | (~dbnc_i & sync2_q);

  AST_DB_TAKES_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((filt_q ^ $past(filt_q)) & (filt_q ^ $past(sync2_q))) == '0)); // R8
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] val_i,
  input  port_cfg_t     cfg_i,
  input  logic [PW-1:0] ack_i,
  output logic [PW-1:0] stat_o
);
  logic [PW-1:0] prev_q, pend_q, pend_d;
  logic [PW-1:0] rise, fall, hit, lvl_match;

  always_comb begin
    rise      = val_i & ~prev_q;
    fall      = ~val_i & prev_q;
    hit       = cfg_i.enable & cfg_i.trig_edge &
                ((rise & cfg_i.pol_hi) | (fall & ~cfg_i.pol_hi));
    pend_d    = (pend_q & ~ack_i & cfg_i.trig_edge & cfg_i.enable) | hit;
    lvl_match = ~(val_i ^ cfg_i.pol_hi);
    stat_o    = cfg_i.enable & ((cfg_i.trig_edge & pend_q) | (~cfg_i.trig_edge & lvl_match));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= val_i;
      pend_q <= pend_d;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(ack_i & ~hit)) == '0)); // R5
  AST_NO_LATCH_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(cfg_i.enable)) == '0)); // R7
  AST_LEVEL_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(cfg_i.trig_edge)) == '0)); // R6
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int DB_CYCLES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wen_i,
  input  logic [7:0]    bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic [7:0]    pin_p0_i,
  input  logic [7:0]    pin_p1_i,
  input  logic [7:0]    pin_p2_i,
  output logic          irq_shared_o,
  output logic [7:0]    irq_pin_o
);
  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic [NPORT-1:0][PW-1:0] pins, vals, stat, ack;
  port_cfg_t [NPORT-1:0]   cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pins = {pin_p2_i, pin_p1_i, pin_p0_i};

  gpio_irq_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .wen_i   (bus_wen_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .stat_i  (stat),
    .cfg_o   (cfg),
    .ack_o   (ack),
    .rdata_o (bus_rdata_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_irq_pin_path #(.PW(PW), .DB_CYCLES(DB_CYCLES)) u_path (
      .clk_i  (clk_i),
      .rst_ni (rst_int_n),
      .pin_i  (pins[p]),
      .dbnc_i (cfg[p].dbnc),
      .val_o  (vals[p])
    );
    gpio_irq_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_int_n),
      .val_i  (vals[p]),
      .cfg_i  (cfg[p]),
      .ack_i  (ack[p]),
      .stat_o (stat[p])
    );
  end

  assign irq_shared_o = |{stat[1], stat[0]};
  assign irq_pin_o    = stat[2];

  AST_SHARED_SILENT_IN_RESET: assert property (@(posedge clk_i)
    !rst_int_n |-> (!irq_shared_o && irq_pin_o == '0)); // R1
endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  import gpio_irq_pkg::*;
  localparam int DBC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic [7:0] pin0 = 8'h00, pin1 = 8'h00, pin2 = 8'h00;
  logic irq_sh;
  logic [7:0] irq_pin;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_unit #(.DB_CYCLES(DBC)) u_gpio_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .bus_wen_i(wen), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_p0_i(pin0),
    .pin_p1_i(pin1), .pin_p2_i(pin2), .irq_shared_o(irq_sh), .irq_pin_o(irq_pin)
  );

  int n_chk = 0, n_fail = 0;

  // behavioural model
  bit [7:0] m_trig[3], m_pol[3], m_ena[3], m_dbn[3];
  bit m_s1[24], m_s2[24], m_flt[24], m_prev[24], m_pend[24];
  int m_cnt[24];
  bit m_rs1, m_rs2;

  function automatic bit m_val(int k);
    return m_dbn[k/8][k%8] ? m_flt[k] : m_s2[k];
  endfunction

  function automatic bit m_stat(int k);
    int p = k / 8, i = k % 8;
    if (!m_ena[p][i]) return 1'b0;
    if (m_trig[p][i]) return m_pend[k];
    return m_val(k) == m_pol[p][i];
  endfunction

  function automatic logic [7:0] m_statbyte(int p);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = m_stat(p*8+i);
    return b;
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] a);
    for (int p = 0; p < 3; p++) begin
      if (a == ADR_TRIG[p]) return m_trig[p];
      if (a == ADR_POL[p])  return m_pol[p];
      if (a == ADR_ENA[p])  return m_ena[p];
      if (a == ADR_DBN[p])  return m_dbn[p];
      if (a == ADR_STAT[p]) return m_statbyte(p);
    end
    return 8'h00;
  endfunction

  task automatic m_clear();
    for (int p = 0; p < 3; p++) begin
      m_trig[p] = 0; m_pol[p] = 0; m_ena[p] = 0; m_dbn[p] = 0;
    end
    for (int k = 0; k < 24; k++) begin
      m_s1[k] = 0; m_s2[k] = 0; m_flt[k] = 0; m_prev[k] = 0; m_pend[k] = 0; m_cnt[k] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); m_rs1 = 0; m_rs2 = 0;
    end else begin
      if (m_rs2) begin
        for (int k = 0; k < 24; k++) begin
          automatic int p = k / 8, i = k % 8;
          automatic bit v = m_val(k);
          automatic bit pin_in = (p == 0) ? pin0[i] : (p == 1) ? pin1[i] : pin2[i];
          automatic bit ackb = wen && addr == ADR_ACK[p] && wdata[i];
          automatic bit hit = m_ena[p][i] && m_trig[p][i] &&
                              ((m_pol[p][i] && v && !m_prev[k]) || (!m_pol[p][i] && !v && m_prev[k]));
          m_pend[k] = (m_pend[k] && !ackb && m_trig[p][i] && m_ena[p][i]) || hit;
          if (m_s2[k] == m_flt[k]) m_cnt[k] = 0;
          else if (m_cnt[k] == DBC - 1) begin m_flt[k] = m_s2[k]; m_cnt[k] = 0; end
          else m_cnt[k] = m_cnt[k] + 1;
          m_prev[k] = v; m_s2[k] = m_s1[k]; m_s1[k] = pin_in;
        end
        if (wen) for (int p = 0; p < 3; p++) begin
          if (addr == ADR_TRIG[p]) m_trig[p] = wdata;
          if (addr == ADR_POL[p])  m_pol[p]  = wdata;
          if (addr == ADR_ENA[p])  m_ena[p]  = wdata;
          if (addr == ADR_DBN[p])  m_dbn[p]  = wdata;
        end
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // compare outputs against model on every clock, away from edges
  always @(posedge clk) begin
    #3;
    if (cmp_on) begin
      chk("R10 shared request", {7'b0, irq_sh}, {7'b0, |{m_statbyte(0), m_statbyte(1)}});
      chk("R11 per-pin request", irq_pin, m_statbyte(2));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wen = 1'b1; addr = a; wdata = d;
    @(negedge clk); wen = 1'b0; addr = 8'h00; wdata = 8'h00;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
    chk({tag, " model"}, rdata, m_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;

    // R1 reset state
    rd_exp(8'h90, 8'h00, "R1 trigger p0");
    rd_exp(8'h58, 8'h00, "R1 enable p2");
    rd_exp(8'hA0, 8'h00, "R1 status p0");
    rd_exp(8'h5C, 8'h00, "R1 status p2");
    chk("R1 irq lines", {irq_sh, irq_pin[6:0]}, 8'h00);

    // R2 map readback
    wr(8'hC4, 8'h3C); rd_exp(8'hC4, 8'h3C, "R2 debounce p1");
    wr(8'h50, 8'h81); rd_exp(8'h50, 8'h81, "R2 polarity p2");
    wr(8'hC4, 8'h00); wr(8'h50, 8'h00);

    // R3 unmapped and status writes ignored
    wr(8'h00, 8'hFF); rd_exp(8'h00, 8'h00, "R3 unmapped read");
    wr(8'hA0, 8'hFF); rd_exp(8'hA0, 8'h00, "R3 status write ignored");
    rd_exp(8'h98, 8'h00, "R3 ack reads zero");

    // R4 edge mode on port 0: pins 0-3 rising, 4-7 falling
    wr(8'h90, 8'hFF); wr(8'h94, 8'h0F); wr(8'h9C, 8'hFF);
    @(negedge clk); pin0 = 8'h11;
    idle(4);
    rd_exp(8'hA0, 8'h01, "R4 rising latched, falling-mode rise ignored");
    @(negedge clk); pin0 = 8'h01;
    idle(4);
    rd_exp(8'hA0, 8'h11, "R4 falling edge latched");
    chk("R10 shared high", {7'b0, irq_sh}, 8'h01);

    // R5 acknowledge clears only written bits
    wr(8'h98, 8'h01); rd_exp(8'hA0, 8'h10, "R5 ack clears bit0 only");
    wr(8'h98, 8'h10); rd_exp(8'hA0, 8'h00, "R5 ack clears bit4");
    // R5 edge and ack on the same edge: edge wins
    @(negedge clk); pin0 = 8'h05;
    @(negedge clk);
    wr(8'h98, 8'h04);
    rd_exp(8'hA0, 8'h04, "R5 same-cycle edge kept");
    wr(8'h98, 8'h04); rd_exp(8'hA0, 8'h00, "R5 later ack clears");

    // R6 level mode on port 1
    wr(8'hB0, 8'hAA); wr(8'hB8, 8'hFF);
    idle(3);
    rd_exp(8'hBC, 8'h55, "R6 level low pins");
    @(negedge clk); pin1 = 8'hF0;
    idle(3);
    rd_exp(8'hBC, 8'hA5, "R6 level follows pins");
    wr(8'hB4, 8'hFF); rd_exp(8'hBC, 8'hA5, "R6 ack no effect");

    // R7 enable gating
    wr(8'hB8, 8'h00); rd_exp(8'hBC, 8'h00, "R7 disabled level");
    wr(8'h9C, 8'h00); wr(8'h94, 8'hF0);
    @(negedge clk); pin0 = 8'hF0;
    idle(2);
    @(negedge clk); pin0 = 8'h0F;
    idle(4);
    wr(8'h9C, 8'hFF);
    idle(1);
    rd_exp(8'hA0, 8'h00, "R7 no spurious after re-enable");
    chk("R7 shared low", {7'b0, irq_sh}, 8'h00);

    // R8 debounce on port 2 pin0, pin1 unfiltered
    wr(8'h4C, 8'hFF); wr(8'h50, 8'hFF); wr(8'h64, 8'h01); wr(8'h58, 8'hFF);
    idle(2);
    @(negedge clk); pin2 = 8'h03;
    idle(2);
    @(negedge clk); pin2 = 8'h00;
    idle(8);
    rd_exp(8'h5C, 8'h02, "R8 short pulse filtered, R9 status p2");
    chk("R11 pin1 request", irq_pin, 8'h02);
    wr(8'h54, 8'h02);
    @(negedge clk); pin2 = 8'h01;
    idle(DBC + 1);
    rd_exp(8'h5C, 8'h00, "R8 not yet accepted");
    idle(3);
    rd_exp(8'h5C, 8'h01, "R8 stable level accepted");
    chk("R11 pin0 request", irq_pin, 8'h01);

    // randomised mix against model
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) pin0 = pin0 ^ (8'h01 << ($urandom % 8));
      if ($urandom % 4 == 0) pin1 = pin1 ^ (8'h01 << ($urandom % 8));
      if ($urandom % 3 == 0) pin2 = pin2 ^ (8'h01 << ($urandom % 8));
      if ($urandom % 12 == 0) begin
        automatic int p = $urandom % 3;
        automatic int s = $urandom % 5;
        automatic logic [7:0] a = (s == 0) ? ADR_TRIG[p] : (s == 1) ? ADR_POL[p] :
                                  (s == 2) ? ADR_ENA[p] : (s == 3) ? ADR_DBN[p] : ADR_ACK[p];
        wr(a, 8'($urandom));
      end
    end
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); addr = ADR_STAT[p]; #1;
      chk("R9 status model", rdata, m_statbyte(p));
    end

    idle(2);
    summary();
    $finish;
  end
endmodule